// File: doc/BRIEF.md
# Accumulator ALU with Decimal Arithmetic and Skip Tests

This block is the purely combinational arithmetic and test stage of a small accumulator machine. It takes the current 8-bit accumulator, the one-bit extend flag, the value of register zero, a 3-bit bit index and a 5-bit operation code. It returns the next accumulator value, the next extend flag and a skip request. The surrounding sequencer registers these results and, when skip is raised, advances past the next two program bytes.

The unary operations are:
- binary increment and decrement, with wrap reported in the extend flag;
- packed two-digit decimal increment and decrement, with carry or borrow reported in the extend flag;
- logical shifts left and right;
- one's complement and clear;
- setting or clearing one selected bit.

The test operations raise skip from one of three sources: a selected accumulator bit, the extend flag, or an unsigned comparison of the accumulator against register zero or against zero. A test operation never alters the accumulator or the extend flag.

The block has no clock, no reset and no storage. Its width is set by a digit count parameter, and the default of two digits gives 8 bits.

Top module: `acc_alu`

## Requirements
- R1: Code 1 (binary increment) gives ACC+1 mod 256. Code 3 (binary decrement) gives ACC-1 mod 256. E is 1 only when the result wraps (0xFF to 0x00, or 0x00 to 0xFF), and is 0 otherwise.
- R2: Codes 2 and 4 treat ACC as two packed BCD digits, with the tens digit in bits 7:4 and the units digit in bits 3:0. Code 2 (decimal increment) maps 0x99 to 0x00 with E=1. Code 4 (decimal decrement) maps 0x00 to 0x99 with E=1. For any other valid BCD input, both codes give the decimal neighbour with E=0.
- R3: Code 7 shifts ACC left with bit 0 filled with zero. Code 8 shifts ACC right with bit 7 filled with zero. Both leave E equal to its input.
- R4: Code 6 inverts every bit of ACC. Code 5 forces ACC to 0x00. Both leave E unchanged.
- R5: Code 9 sets bit N of ACC, and code 10 clears bit N, where N is the bit index input. All other bits and E are unchanged.
- R6: Code 13 raises skip when ACC bit N is 1. Code 14 raises skip when ACC bit N is 0.
- R7: Code 15 raises skip when E is 1, and code 16 raises skip when E is 0. Code 11 forces E to 1, and code 12 forces E to 0. None of these four codes changes ACC.
- R8: The comparisons against R0 are unsigned, and each raises skip when its condition holds: code 17 ACC<R0, code 18 ACC==R0, code 19 ACC<=R0, code 20 ACC>=R0, code 21 ACC!=R0, code 22 ACC>R0.
- R9: Code 23 raises skip when ACC is 0x00. Code 24 raises skip when ACC is not 0x00.
- R10: Codes 13 to 24 leave ACC and E unchanged. Codes 1 to 12 never raise skip. Code 0 and codes 25 to 31 pass ACC and E through unchanged with skip low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Operation select (codes listed in the requirements) |
| bit_sel | input | 3 | Bit index N for the bit operations and bit tests |
| acc_in | input | 8 | Current accumulator |
| r0_in | input | 8 | Register zero, the comparison operand |
| ext_in | input | 1 | Current extend flag E |
| acc_out | output | 8 | Next accumulator |
| ext_out | output | 1 | Next extend flag |
| skip_out | output | 1 | Request to skip the next two program bytes |

## Verification
Each operation code drives two outcomes from the same inputs at once: the data result (accumulator and extend flag) and the skip decision. The risk is that one of them leaks into the other. An arithmetic code might raise skip, or a test code might disturb the accumulator or E. The bench drives every code, including the unused ones, against shared operand patterns. On each clock it compares all three outputs together against a behavioural model. Directed vectors add the decimal and binary wrap points, equal operands for the comparisons, and shifts with E at both values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [4:0] {
        OP_NOP      = 5'd0,
        OP_INC_BIN  = 5'd1,
        OP_INC_DEC  = 5'd2,
        OP_DEC_BIN  = 5'd3,
        OP_DEC_DEC  = 5'd4,
        OP_CLEAR    = 5'd5,
        OP_INVERT   = 5'd6,
        OP_SHL      = 5'd7,
        OP_SHR      = 5'd8,
        OP_BIT_SET  = 5'd9,
        OP_BIT_CLR  = 5'd10,
        OP_E_SET    = 5'd11,
        OP_E_CLR    = 5'd12,
        OP_SK_BIT1  = 5'd13,
        OP_SK_BIT0  = 5'd14,
        OP_SK_E1    = 5'd15,
        OP_SK_E0    = 5'd16,
        OP_SK_LT    = 5'd17,
        OP_SK_EQ    = 5'd18,
        OP_SK_LE    = 5'd19,
        OP_SK_GE    = 5'd20,
        OP_SK_NE    = 5'd21,
        OP_SK_GT    = 5'd22,
        OP_SK_ZERO  = 5'd23,
        OP_SK_NZERO = 5'd24
    } alu_op_e;

    localparam int unsigned NIBBLE_W = 4;

endpackage

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd
    import acc_alu_pkg::*;
#(
    parameter int unsigned DIGITS = 2,
    localparam int unsigned W = NIBBLE_W * DIGITS
) (
    input  logic [W-1:0] value_in,
    input  logic         count_down,
    output logic [W-1:0] value_out,
    output logic         wrap_out
);

    logic [DIGITS:0] ripple;

    assign ripple[0] = 1'b1;
    assign wrap_out  = ripple[DIGITS];

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [NIBBLE_W-1:0] digit;
        logic [NIBBLE_W-1:0] next_digit;
        logic                pass_on;

        assign digit = value_in[g*NIBBLE_W +: NIBBLE_W];

        always_comb begin
            next_digit = digit;
            pass_on    = 1'b0;
            if (ripple[g]) begin
                if (count_down) begin
                    if (digit == 4'd0) begin
                        next_digit = 4'd9;
                        pass_on    = 1'b1;
                    end else begin
                        next_digit = digit - 4'd1;
                    end
                end else begin
                    if (digit >= 4'd9) begin
                        next_digit = 4'd0;
                        pass_on    = 1'b1;
                    end else begin
                        next_digit = digit + 4'd1;
                    end
                end
            end
        end

        assign value_out[g*NIBBLE_W +: NIBBLE_W] = next_digit;
        assign ripple[g+1] = pass_on;

        // R2: for a valid decimal input digit, the result digit stays decimal
        always_comb begin
            if (digit <= 4'd9) begin
                p_digit_valid_r2: assert (next_digit <= 4'd9)
                    else $error("decimal digit out of range");
            end
        end
    end

endmodule

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
    import acc_alu_pkg::*;
#(
    parameter int unsigned DIGITS = 2,
    localparam int unsigned W     = NIBBLE_W * DIGITS,
    localparam int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     acc_in,
    input  logic [IDX_W-1:0] bit_sel,
    output logic [W-1:0]     inc_val,
    output logic             inc_wrap,
    output logic [W-1:0]     dec_val,
    output logic             dec_wrap,
    output logic [W-1:0]     shl_val,
    output logic [W-1:0]     shr_val,
    output logic [W-1:0]     inv_val,
    output logic [W-1:0]     set_val,
    output logic [W-1:0]     clr_val
);

    logic [W:0]   inc_wide;
    logic [W:0]   dec_wide;
    logic [W-1:0] bit_mask;

    assign inc_wide = {1'b0, acc_in} + {{W{1'b0}}, 1'b1};
    assign dec_wide = {1'b0, acc_in} - {{W{1'b0}}, 1'b1};
    assign inc_val  = inc_wide[W-1:0];
    assign inc_wrap = inc_wide[W];
    assign dec_val  = dec_wide[W-1:0];
    assign dec_wrap = dec_wide[W];

    assign shl_val = {acc_in[W-2:0], 1'b0};
    assign shr_val = {1'b0, acc_in[W-1:1]};
    assign inv_val = ~acc_in;

    always_comb begin
        bit_mask          = '0;
        bit_mask[bit_sel] = 1'b1;
    end

    assign set_val = acc_in | bit_mask;
    assign clr_val = acc_in & ~bit_mask;

    // R1: an increment wrap leaves zero, a decrement wrap leaves all ones
    always_comb begin
        if (inc_wrap) begin
            p_inc_wrap_zero_r1: assert (inc_val == '0)
                else $error("increment wrap not zero");
        end
        if (dec_wrap) begin
            p_dec_wrap_ones_r1: assert (dec_val == '1)
                else $error("decrement wrap not all ones");
        end
    end

endmodule

// File: rtl/acc_alu_skip.sv
module acc_alu_skip
    import acc_alu_pkg::*;
#(
    parameter int unsigned DIGITS = 2,
    localparam int unsigned W     = NIBBLE_W * DIGITS,
    localparam int unsigned IDX_W = $clog2(W)
) (
    input  alu_op_e          op,
    input  logic [W-1:0]     acc_in,
    input  logic [W-1:0]     r0_in,
    input  logic             ext_in,
    input  logic [IDX_W-1:0] bit_sel,
    output logic             skip
);

    logic below;
    logic same;
    logic above;
    logic acc_zero;
    logic tested_bit;

    assign below      = acc_in < r0_in;
    assign above      = acc_in > r0_in;
    assign same       = acc_in == r0_in;
    assign acc_zero   = acc_in == '0;
    assign tested_bit = acc_in[bit_sel];

    always_comb begin
        skip = 1'b0;
        unique case (op)
            OP_SK_BIT1:  skip = tested_bit;
            OP_SK_BIT0:  skip = ~tested_bit;
            OP_SK_E1:    skip = ext_in;
            OP_SK_E0:    skip = ~ext_in;
            OP_SK_LT:    skip = below;
            OP_SK_EQ:    skip = same;
            OP_SK_LE:    skip = below | same;
            OP_SK_GE:    skip = above | same;
            OP_SK_NE:    skip = ~same;
            OP_SK_GT:    skip = above;
            OP_SK_ZERO:  skip = acc_zero;
            OP_SK_NZERO: skip = ~acc_zero;
            default:     skip = 1'b0;
        endcase
    end

    // R8: exactly one ordering relation holds between ACC and R0
    always_comb begin
        p_order_onehot_r8: assert ($onehot({below, same, above}))
            else $error("comparison relations not exclusive");
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int unsigned DIGITS = 2,
    localparam int unsigned W     = NIBBLE_W * DIGITS,
    localparam int unsigned IDX_W = $clog2(W)
) (
    input  logic [4:0]       op_code,
    input  logic [IDX_W-1:0] bit_sel,
    input  logic [W-1:0]     acc_in,
    input  logic [W-1:0]     r0_in,
    input  logic             ext_in,
    output logic [W-1:0]     acc_out,
    output logic             ext_out,
    output logic             skip_out
);

    alu_op_e op;
    assign op = alu_op_e'(op_code);

    logic [W-1:0] inc_val, dec_val, shl_val, shr_val, inv_val, set_val, clr_val;
    logic         inc_wrap, dec_wrap;
    logic [W-1:0] bcd_val;
    logic         bcd_wrap;

    acc_alu_unary #(.DIGITS(DIGITS)) u_unary (
        .acc_in   (acc_in),
        .bit_sel  (bit_sel),
        .inc_val  (inc_val),
        .inc_wrap (inc_wrap),
        .dec_val  (dec_val),
        .dec_wrap (dec_wrap),
        .shl_val  (shl_val),
        .shr_val  (shr_val),
        .inv_val  (inv_val),
        .set_val  (set_val),
        .clr_val  (clr_val)
    );

    acc_alu_bcd #(.DIGITS(DIGITS)) u_bcd (
        .value_in   (acc_in),
        .count_down (op == OP_DEC_DEC),
        .value_out  (bcd_val),
        .wrap_out   (bcd_wrap)
    );

    acc_alu_skip #(.DIGITS(DIGITS)) u_skip (
        .op      (op),
        .acc_in  (acc_in),
        .r0_in   (r0_in),
        .ext_in  (ext_in),
        .bit_sel (bit_sel),
        .skip    (skip_out)
    );

    always_comb begin
        acc_out = acc_in;
        ext_out = ext_in;
        unique case (op)
            OP_INC_BIN: begin acc_out = inc_val; ext_out = inc_wrap; end
            OP_DEC_BIN: begin acc_out = dec_val; ext_out = dec_wrap; end
            OP_INC_DEC,
            OP_DEC_DEC: begin acc_out = bcd_val; ext_out = bcd_wrap; end
            OP_CLEAR:   acc_out = '0;
            OP_INVERT:  acc_out = inv_val;
            OP_SHL:     acc_out = shl_val;
            OP_SHR:     acc_out = shr_val;
            OP_BIT_SET: acc_out = set_val;
            OP_BIT_CLR: acc_out = clr_val;
            OP_E_SET:   ext_out = 1'b1;
            OP_E_CLR:   ext_out = 1'b0;
            default:    ;
        endcase
    end

    // R10: a raised skip never comes with a changed accumulator or flag
    // R3: shifts keep E and fill the vacated end with zero
    always_comb begin
        if (skip_out) begin
            p_skip_quiet_r10: assert (acc_out == acc_in && ext_out == ext_in)
                else $error("skip changed data");
        end
        if (op == OP_SHL) begin
            p_shl_fill_r3: assert (acc_out[0] == 1'b0 && ext_out == ext_in)
                else $error("left shift fill or E wrong");
        end
        if (op == OP_SHR) begin
            p_shr_fill_r3: assert (acc_out[W-1] == 1'b0 && ext_out == ext_in)
                else $error("right shift fill or E wrong");
        end
    end

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [4:0] op_code;
    logic [2:0] bit_sel;
    logic [7:0] acc_in, r0_in;
    logic       ext_in;
    logic [7:0] acc_out;
    logic       ext_out, skip_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu u_acc_alu (
        .op_code  (op_code),
        .bit_sel  (bit_sel),
        .acc_in   (acc_in),
        .r0_in    (r0_in),
        .ext_in   (ext_in),
        .acc_out  (acc_out),
        .ext_out  (ext_out),
        .skip_out (skip_out)
    );

    function automatic string req_of(int op);
        case (op)
            1, 3:           return "R1";
            2, 4:           return "R2";
            7, 8:           return "R3";
            5, 6:           return "R4";
            9, 10:          return "R5";
            13, 14:         return "R6";
            11, 12, 15, 16: return "R7";
            17, 18, 19, 20, 21, 22: return "R8";
            23, 24:         return "R9";
            default:        return "R10";
        endcase
    endfunction

    function automatic logic [9:0] model(int op, int n, int a, int r, int e);
        int na = a;
        int ne = e;
        int sk = 0;
        int v;
        case (op)
            1: begin na = a + 1; ne = 0; if (na > 255) begin na = 0; ne = 1; end end
            3: begin na = a - 1; ne = 0; if (na < 0) begin na = 255; ne = 1; end end
            2: begin
                v = (a / 16) * 10 + (a % 16) + 1; ne = 0;
                if (v >= 100) begin v = 0; ne = 1; end
                na = (v / 10) * 16 + (v % 10);
            end
            4: begin
                v = (a / 16) * 10 + (a % 16) - 1; ne = 0;
                if (v < 0) begin v = 99; ne = 1; end
                na = (v / 10) * 16 + (v % 10);
            end
            5:  na = 0;
            6:  na = 255 - a;
            7:  na = (a * 2) % 256;
            8:  na = a / 2;
            9:  na = a | (1 << n);
            10: na = a & (255 - (1 << n));
            11: ne = 1;
            12: ne = 0;
            13: sk = (a >> n) & 1;
            14: sk = ((a >> n) & 1) == 0 ? 1 : 0;
            15: sk = e;
            16: sk = (e == 0) ? 1 : 0;
            17: sk = (a < r) ? 1 : 0;
            18: sk = (a == r) ? 1 : 0;
            19: sk = (a <= r) ? 1 : 0;
            20: sk = (a >= r) ? 1 : 0;
            21: sk = (a != r) ? 1 : 0;
            22: sk = (a > r) ? 1 : 0;
            23: sk = (a == 0) ? 1 : 0;
            24: sk = (a != 0) ? 1 : 0;
            default: ;
        endcase
        return {na[7:0], ne[0], sk[0]};
    endfunction

    task automatic apply(input int op, input int n, input int a, input int r, input int e);
        logic [9:0] exp_v;
        logic [9:0] got_v;
        @(posedge clk);
        #1;
        op_code = op[4:0];
        bit_sel = n[2:0];
        acc_in  = a[7:0];
        r0_in   = r[7:0];
        ext_in  = e[0];
        @(negedge clk);
        exp_v = model(op, n, a, r, e);
        got_v = {acc_out, ext_out, skip_out};
        checks++;
        if (got_v !== exp_v) begin
            errors++;
            $display("FAIL %s op=%0d n=%0d acc=%02h r0=%02h e=%0d: got acc=%02h e=%0d skip=%0d, expected acc=%02h e=%0d skip=%0d",
                     req_of(op), op, n, a, r, e, got_v[9:2], got_v[1], got_v[0],
                     exp_v[9:2], exp_v[1], exp_v[0]);
        end
    endtask

    function automatic int to_bcd(int x);
        return (((x % 100) / 10) * 16) + (x % 10);
    endfunction

    initial begin
        op_code = '0; bit_sel = '0; acc_in = '0; r0_in = '0; ext_in = 1'b0;
        // R10: idle code passes everything through
        apply(0, 0, 8'h5A, 8'h00, 1);
        // R1 wrap points and a plain step
        apply(1, 0, 8'hFF, 0, 0);
        apply(1, 0, 8'h7F, 0, 1);
        apply(3, 0, 8'h00, 0, 0);
        apply(3, 0, 8'h80, 0, 1);
        // R2 decimal carries and borrows
        apply(2, 0, 8'h99, 0, 0);
        apply(2, 0, 8'h09, 0, 1);
        apply(2, 0, 8'h49, 0, 0);
        apply(4, 0, 8'h00, 0, 0);
        apply(4, 0, 8'h10, 0, 1);
        apply(4, 0, 8'h90, 0, 0);
        // R3 shifts with E at both values
        apply(7, 0, 8'h81, 0, 1);
        apply(8, 0, 8'h81, 0, 0);
        apply(8, 0, 8'hFF, 0, 1);
        // R4
        apply(6, 0, 8'hA5, 0, 1);
        apply(5, 0, 8'hFF, 0, 1);
        // R5 extreme bit indices
        apply(9, 7, 8'h00, 0, 0);
        apply(10, 0, 8'hFF, 0, 1);
        // R6
        apply(13, 7, 8'h80, 0, 0);
        apply(14, 3, 8'hF7, 0, 0);
        // R7
        apply(11, 0, 8'h33, 0, 0);
        apply(12, 0, 8'h33, 0, 1);
        apply(15, 0, 8'h00, 0, 1);
        apply(16, 0, 8'h00, 0, 1);
        // R8 equal and unsigned high-bit operands
        for (int op = 17; op <= 22; op++) begin
            apply(op, 0, 8'h80, 8'h80, 0);
            apply(op, 0, 8'h80, 8'h7F, 0);
            apply(op, 0, 8'h01, 8'hFE, 1);
        end
        // R9
        apply(23, 0, 8'h00, 8'h11, 0);
        apply(24, 0, 8'h00, 8'h11, 0);
        apply(24, 0, 8'h40, 8'h11, 0);
        // R10 unused codes
        apply(31, 5, 8'hC3, 8'h12, 1);
        apply(25, 2, 8'h3C, 8'h12, 0);

        // sweep of every code against pseudo-random operands
        for (int cyc = 0; cyc < 4000; cyc++) begin
            int op, a, r, e, n;
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            op = cyc % 32;
            a  = int'(seed & 32'hFF);
            r  = int'((seed >> 8) & 32'hFF);
            e  = int'((seed >> 16) & 32'h1);
            n  = int'((seed >> 20) & 32'h7);
            if (op == 2 || op == 4) a = to_bcd(a);
            if (((seed >> 24) & 32'h3) == 0) r = a;
            if (((seed >> 26) & 32'h7) == 0) a = 0;
            apply(op, n, a, r, e);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule